// File: doc/BRIEF.md
# DRAM Refresh Timing Sequencer

This block produces the periodic refresh cycles that an asynchronous DRAM array needs. Software programs a single 15-bit control word. It sets the refresh period in multiples of sixteen bus clocks, how long the row strobe stays low during a refresh, and how long a precharge gap follows. A two-stage prescaled counter raises a refresh request when the period runs out.

When a request is raised, the block withdraws its grant to the normal access engine. It waits for any access in flight to finish, then runs a column-before-row refresh. All column strobes fall one clock ahead of the row strobe. The row strobe is held for the programmed number of clocks, and both strobes are released together. The grant stays withdrawn for the programmed precharge gap, and only then is access handed back.

The control word also carries a sticky synchronous-mode select and an address-multiplex disable. Both are passed on to the rest of the memory controller. While synchronous mode is selected, this sequencer starts no refreshes.

Top module: `dram_refresh_seq`

## Requirements
- R1: Control word bits [14:6] hold a 9-bit period code P; when accesses never block, successive refresh starts (column strobes falling) are exactly (P+1)*16 clocks apart.
- R2: A refresh asserts every column strobe (cas_n all 0) for exactly one clock with ras_n high, then drives ras_n low with cas_n still all 0, and raises all column strobes in the same clock as ras_n.
- R3: Control word bits [1:0] set the row strobe low time: 00 gives 2 clocks, 01 gives 3, 10 gives 4, 11 gives 5.
- R4: Control word bits [3:2] set the precharge gap after ras_n rises: 00 gives 1 clock, 01 gives 2, 10 gives 3, 11 gives 4; acc_grant stays low for exactly that gap and during the whole strobe sequence.
- R5: acc_grant goes low as soon as a refresh is due; while acc_busy is high no refresh starts, and the column strobes fall in the clock after acc_busy is first sampled low.
- R6: The period counter reloads when a refresh starts, so the next start after a deferred refresh follows it by (P+1)*16 clocks.
- R7: A new period code written while the counter runs takes effect only at the next reload; the interval already counting keeps the old value.
- R8: After reset no refresh occurs until the control word has been written once; the first write loads the period counter.
- R9: Control word bit [5] selects synchronous mode (reset value 0) and drives sync_sel; once set, writing 0 does not clear it, only reset does; while it is set no refresh starts and acc_grant stays high.
- R10: Control word bit [4] is driven on no_mux from the clock after the write.
- R11: During and straight after reset, ras_n is 1, all cas_n bits are 1 and acc_grant is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 15 | Control word value |
| acc_busy | input | 1 | Access engine has an access in progress |
| acc_grant | output | 1 | Access engine may start a new access |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | NCAS | Column strobes, active low, one per lane |
| no_mux | output | 1 | Column address multiplexing disabled |
| sync_sel | output | 1 | Synchronous DRAM mode selected (sticky) |

## Verification
The bench sweeps the strobe and gap encodings at their extremes and at their midpoints. A wrong decode shows up as a row pulse or grant gap that is off by one clock. It holds acc_busy across the due point to check that a start is deferred and not dropped. This also checks that the next interval is timed from the deferred start and not from the due point; a design that reloads on the request would give a short interval there. It changes the period code mid-interval, where a design that loads immediately would cut the running interval short. It checks that synchronous mode cannot be cleared by a write, since a design that cleared it would resume refreshing.

// File: rtl/drfs_pkg.sv
// Package: shared types and field positions for the DRAM refresh sequencer.
// Assumes a 15-bit control word; positions below are the decode contract.
package drfs_pkg;

    localparam int CFG_W      = 15;
    localparam int CODE_W     = 9;
    localparam int PRE_W      = 4;
    localparam int LEN_W      = 2;
    localparam int SEQ_CNT_W  = 3;

    localparam int F_RAS_LO   = 0;
    localparam int F_GAP_LO   = 2;
    localparam int F_NOMUX    = 4;
    localparam int F_SYNC     = 5;
    localparam int F_CODE_LO  = 6;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LEAD   = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_GAP    = 2'd3
    } seq_state_e;

endpackage

// File: rtl/drfs_cfg_reg.sv
// Module: control word holder.
// Splits the written word into fields, keeps the synchronous-mode bit
// sticky until reset, and emits a one-clock arm pulse after the very
// first write so the period counter can be loaded. Field contents before
// the first write are held at zero but are not used (armed stays low).
module drfs_cfg_reg
    import drfs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CFG_W-1:0]     wr_data,
    output logic [CODE_W-1:0]    period_code,
    output logic [LEN_W-1:0]     ras_code,
    output logic [LEN_W-1:0]     gap_code,
    output logic                 no_mux,
    output logic                 sync_sel,
    output logic                 armed,
    output logic                 arm_pulse
);

    logic [CODE_W-1:0] period_q;
    logic [LEN_W-1:0]  ras_q;
    logic [LEN_W-1:0]  gap_q;
    logic              nomux_q;
    logic              sync_q;
    logic              armed_q;
    logic              arm_q;

    // Capture the plain fields on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            ras_q    <= '0;
            gap_q    <= '0;
            nomux_q  <= 1'b0;
        end else if (wr_en) begin
            period_q <= wr_data[F_CODE_LO +: CODE_W];
            ras_q    <= wr_data[F_RAS_LO  +: LEN_W];
            gap_q    <= wr_data[F_GAP_LO  +: LEN_W];
            nomux_q  <= wr_data[F_NOMUX];
        end
    end

    // Synchronous-mode select can only be set by a write, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
        end else if (wr_en) begin
            sync_q <= sync_q | wr_data[F_SYNC];
        end
    end

    // Track the first write and pulse once so the counter loads the new code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            arm_q   <= 1'b0;
        end else begin
            arm_q <= wr_en && !armed_q;
            if (wr_en) begin
                armed_q <= 1'b1;
            end
        end
    end

    assign period_code = period_q;
    assign ras_code    = ras_q;
    assign gap_code    = gap_q;
    assign no_mux      = nomux_q;
    assign sync_sel    = sync_q;
    assign armed       = armed_q;
    assign arm_pulse   = arm_q;

endmodule

// File: rtl/drfs_interval_timer.sv
// Module: prescaled refresh period counter.
// A PRE_W-bit prescaler divides the clock by 2**PRE_W and a CODE_W-bit
// major counter counts prescaler wraps. A load sets it so that 'due'
// rises (code+1)*2**PRE_W - 1 clocks later; it then holds at zero until
// the next load. Assumes load is pulsed at refresh start.
module drfs_interval_timer #(
    parameter int PRE_W  = 4,
    parameter int CODE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              load,
    input  logic [CODE_W-1:0] load_code,
    output logic              due
);

    logic [PRE_W-1:0]  pre_q;
    logic [CODE_W-1:0] maj_q;
    logic              pre_zero;
    logic              maj_zero;

    assign pre_zero = (pre_q == '0);
    assign maj_zero = (maj_q == '0);

    // Reload on request, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            maj_q <= '0;
        end else if (load) begin
            pre_q <= '1;
            maj_q <= load_code;
        end else if (en) begin
            if (!pre_zero) begin
                pre_q <= pre_q - 1'b1;
            end else if (!maj_zero) begin
                pre_q <= '1;
                maj_q <= maj_q - 1'b1;
            end
        end
    end

    assign due = en && pre_zero && maj_zero;

endmodule

// File: rtl/drfs_strobe_fsm.sv
// Module: refresh strobe sequencer and access arbitration.
// Withdraws the grant while a refresh is due, starts once the access
// engine is idle, then walks lead (columns only), active (row and
// columns) and gap (precharge, grant held low). Strobe lengths are
// snapshotted at start. Strobes are registered from the next state.
module drfs_strobe_fsm
    import drfs_pkg::*;
#(
    parameter int NCAS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              due,
    input  logic              acc_busy,
    input  logic [LEN_W-1:0]  ras_code,
    input  logic [LEN_W-1:0]  gap_code,
    output logic              start,
    output logic              acc_grant,
    output logic              ras_n,
    output logic [NCAS-1:0]   cas_n
);

    seq_state_e           state_q, state_d;
    logic [SEQ_CNT_W-1:0] cnt_q, cnt_d;
    logic [SEQ_CNT_W-1:0] ras_m1_q, gap_m1_q;
    logic                 ras_q;
    logic                 col_on_d;

    assign start = (state_q == ST_IDLE) && due && !acc_busy;

    // Next-state and phase counter selection.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_LEAD;
                end
            end
            ST_LEAD: begin
                state_d = ST_ACTIVE;
                cnt_d   = ras_m1_q;
            end
            ST_ACTIVE: begin
                if (cnt_q == '0) begin
                    state_d = ST_GAP;
                    cnt_d   = gap_m1_q;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_GAP: begin
                if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, phase counter and length snapshot registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            ras_m1_q <= '0;
            gap_m1_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (start) begin
                ras_m1_q <= SEQ_CNT_W'(ras_code) + SEQ_CNT_W'(1);
                gap_m1_q <= SEQ_CNT_W'(gap_code);
            end
        end
    end

    assign col_on_d = (state_d == ST_LEAD) || (state_d == ST_ACTIVE);

    // Registered row strobe, low only in the active phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q <= 1'b1;
        end else begin
            ras_q <= (state_d != ST_ACTIVE);
        end
    end

    // One registered column strobe per lane, all driven alike.
    for (genvar g = 0; g < NCAS; g++) begin : g_lane
        logic cas_q;
        // Lane flop: low through lead and active phases.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cas_q <= 1'b1;
            end else begin
                cas_q <= !col_on_d;
            end
        end
        assign cas_n[g] = cas_q;
    end

    assign ras_n     = ras_q;
    assign acc_grant = (state_q == ST_IDLE) && !due;

endmodule

// File: rtl/dram_refresh_seq.sv
// Module: top of the DRAM refresh sequencer.
// Ties the control word, period counter and strobe sequencer together.
// The counter reloads at the arming write and at every refresh start;
// synchronous mode masks the due request so no refresh begins.
module dram_refresh_seq
    import drfs_pkg::*;
#(
    parameter int NCAS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [14:0]       cfg_wdata,
    input  logic              acc_busy,
    output logic              acc_grant,
    output logic              ras_n,
    output logic [NCAS-1:0]   cas_n,
    output logic              no_mux,
    output logic              sync_sel
);

    logic [CODE_W-1:0] period_code;
    logic [LEN_W-1:0]  ras_code;
    logic [LEN_W-1:0]  gap_code;
    logic              armed;
    logic              arm_pulse;
    logic              due_raw;
    logic              due;
    logic              start;

    drfs_cfg_reg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr),
        .wr_data     (cfg_wdata),
        .period_code (period_code),
        .ras_code    (ras_code),
        .gap_code    (gap_code),
        .no_mux      (no_mux),
        .sync_sel    (sync_sel),
        .armed       (armed),
        .arm_pulse   (arm_pulse)
    );

    drfs_interval_timer #(
        .PRE_W  (PRE_W),
        .CODE_W (CODE_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (armed),
        .load      (start || arm_pulse),
        .load_code (period_code),
        .due       (due_raw)
    );

    assign due = due_raw && !sync_sel;

    drfs_strobe_fsm #(
        .NCAS (NCAS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .due       (due),
        .acc_busy  (acc_busy),
        .ras_code  (ras_code),
        .gap_code  (gap_code),
        .start     (start),
        .acc_grant (acc_grant),
        .ras_n     (ras_n),
        .cas_n     (cas_n)
    );

endmodule

// File: rtl/drfs_chk.sv
// Module: protocol checker for the DRAM refresh sequencer, bound to the top.
// Observes ports only; a small counter tracks row strobe low time.
module drfs_chk #(
    parameter int NCAS = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            acc_busy,
    input logic            acc_grant,
    input logic            ras_n,
    input logic [NCAS-1:0] cas_n,
    input logic            sync_sel
);

    logic [3:0] ras_run;

    // Count consecutive clocks with the row strobe low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_run <= '0;
        end else if (!ras_n) begin
            ras_run <= (ras_run == 4'hF) ? ras_run : ras_run + 1'b1;
        end else begin
            ras_run <= '0;
        end
    end

    a_r2_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> ($past(cas_n) == '0));

    a_r2_cas_held_with_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (cas_n == '0));

    a_r2_release_together: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (cas_n == '1));

    a_r3_ras_max_len: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (ras_run < 4'd5));

    a_r4_no_grant_in_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || (cas_n != '1)) |-> !acc_grant);

    a_r4_no_grant_first_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> !acc_grant);

    a_r5_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cas_n) == '1) && (cas_n == '0)) |-> !$past(acc_busy));

    a_r9_sync_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sync_sel |=> sync_sel);

endmodule

bind dram_refresh_seq drfs_chk #(.NCAS(NCAS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_busy  (acc_busy),
    .acc_grant (acc_grant),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .sync_sel  (sync_sel)
);

// File: tb/dram_refresh_seq_bench.sv
// Bench: table-driven sweep of period and strobe encodings, then directed
// tests for reset, arming, deferral, late period change and mode bits.
module dram_refresh_seq_bench;

    localparam int NCAS = 4;
    localparam int NVEC = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_wr = 1'b0;
    logic [14:0]     cfg_wdata = '0;
    logic            acc_busy = 1'b0;
    logic            acc_grant;
    logic            ras_n;
    logic [NCAS-1:0] cas_n;
    logic            no_mux;
    logic            sync_sel;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Vector: {period code 9, ras code 2, gap code 2, interval 14, ras len 3, gap len 3}
    localparam logic [32:0] TBL [NVEC] = '{
        {9'd0, 2'd0, 2'd0, 14'd16, 3'd2, 3'd1},
        {9'd1, 2'd1, 2'd2, 14'd32, 3'd3, 3'd3},
        {9'd2, 2'd2, 2'd1, 14'd48, 3'd4, 3'd2},
        {9'd3, 2'd3, 2'd3, 14'd64, 3'd5, 3'd4},
        {9'd5, 2'd0, 2'd3, 14'd96, 3'd2, 3'd4}
    };

    dram_refresh_seq #(.NCAS(NCAS)) u_dram_refresh_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .acc_busy  (acc_busy),
        .acc_grant (acc_grant),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .no_mux    (no_mux),
        .sync_sel  (sync_sel)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Watchdog: a hung run counts as one failure and still reports.
    always @(posedge clk) begin
        if (!done && cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, act cycles=%0d exp below 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [14:0] word(input int code, input int rc,
                                         input int gc, input bit nm, input bit sy);
        return {code[8:0], sy, nm, gc[1:0], rc[1:0]};
    endfunction

    task automatic wr(input logic [14:0] w);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    // Wait for a refresh start and measure its phases at negedges.
    task automatic measure(output int t0, output int lead, output int rl,
                           output int gl, output int cas_ok);
        int wait_n = 0;
        t0 = -1; lead = 0; rl = 0; gl = 0; cas_ok = 1;
        @(negedge clk);
        while (cas_n == '1) begin
            wait_n++;
            if (wait_n > 20000) begin
                chk("R1 refresh never started", 0, 1);
                return;
            end
            @(negedge clk);
        end
        t0 = cyc;
        while (cas_n == '0 && ras_n) begin lead++; @(negedge clk); end
        while (!ras_n) begin
            rl++;
            if (cas_n != '0) cas_ok = 0;
            @(negedge clk);
        end
        if (cas_n != '1) cas_ok = 0;
        while (!acc_grant && gl < 100) begin gl++; @(negedge clk); end
    endtask

    initial begin
        int t1, t2, t3, t4, ld, rl, gl, ok, rel, falls, grant_lo;

        // R11: reset state held for several clocks.
        repeat (3) @(negedge clk);
        chk("R11 ras_n in reset", int'(ras_n), 1);
        chk("R11 cas_n in reset", int'(cas_n), 15);
        chk("R11 grant in reset", int'(acc_grant), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 ras_n after reset", int'(ras_n), 1);
        chk("R11 grant after reset", int'(acc_grant), 1);
        chk("R9 sync_sel reset value", int'(sync_sel), 0);
        chk("R10 no_mux reset value", int'(no_mux), 0);

        // R8: no refresh before the first write.
        falls = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (cas_n != '1 || !ras_n) falls++;
        end
        chk("R8 no refresh before first write", falls, 0);

        // R1 R2 R3 R4: table sweep.
        for (int v = 0; v < NVEC; v++) begin
            logic [32:0] e;
            e = TBL[v];
            wr(word(int'(e[32:24]), int'(e[23:22]), int'(e[21:20]), 1'b0, 1'b0));
            measure(t1, ld, rl, gl, ok);
            measure(t2, ld, rl, gl, ok);
            chk($sformatf("R1 interval vec%0d", v), t2 - t1, int'(e[19:6]));
            chk($sformatf("R2 cas lead vec%0d", v), ld, 1);
            chk($sformatf("R2 cas held/released vec%0d", v), ok, 1);
            chk($sformatf("R3 ras length vec%0d", v), rl, int'(e[5:3]));
            chk($sformatf("R4 gap length vec%0d", v), gl, int'(e[2:0]));
        end

        // R7: period change takes effect at the next reload.
        wr(word(4, 0, 0, 1'b0, 1'b0));
        measure(t1, ld, rl, gl, ok);
        measure(t2, ld, rl, gl, ok);
        wr(word(0, 0, 0, 1'b0, 1'b0));
        measure(t3, ld, rl, gl, ok);
        measure(t4, ld, rl, gl, ok);
        chk("R7 running interval keeps old code", t3 - t2, 80);
        chk("R7 new code after reload", t4 - t3, 16);

        // R5 R6: busy across the due point defers the refresh.
        wr(word(3, 0, 0, 1'b0, 1'b0));
        measure(t1, ld, rl, gl, ok);
        measure(t1, ld, rl, gl, ok);
        while (cyc < t1 + 40) @(negedge clk);
        acc_busy = 1'b1;
        falls = 0;
        grant_lo = 0;
        while (cyc < t1 + 100) begin
            @(negedge clk);
            if (cas_n != '1) falls++;
            if (cyc == t1 + 70 && !acc_grant) grant_lo = 1;
        end
        chk("R5 no refresh while busy", falls, 0);
        chk("R5 grant withdrawn when due", grant_lo, 1);
        acc_busy = 1'b0;
        rel = cyc;
        measure(t2, ld, rl, gl, ok);
        chk("R5 start one clock after busy drops", t2 - rel, 1);
        measure(t3, ld, rl, gl, ok);
        chk("R6 interval timed from deferred start", t3 - t2, 64);

        // R10: address-multiplex disable bit.
        wr(word(3, 0, 0, 1'b1, 1'b0));
        chk("R10 no_mux set", int'(no_mux), 1);
        wr(word(3, 0, 0, 1'b0, 1'b0));
        chk("R10 no_mux cleared", int'(no_mux), 0);

        // R9: synchronous select is sticky and stops refresh.
        wr(word(0, 0, 0, 1'b0, 1'b1));
        chk("R9 sync_sel set", int'(sync_sel), 1);
        repeat (15) @(negedge clk);
        wr(word(0, 0, 0, 1'b0, 1'b0));
        chk("R9 sync_sel not cleared by write", int'(sync_sel), 1);
        falls = 0;
        grant_lo = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (cas_n != '1 || !ras_n) falls++;
            if (!acc_grant) grant_lo++;
        end
        chk("R9 no refresh in sync mode", falls, 0);
        chk("R9 grant held in sync mode", grant_lo, 0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 sync_sel cleared by reset", int'(sync_sel), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule